// File: doc/BRIEF.md
# Three-Channel Timer Register Interface

This block is the processor-side register front end of a three-channel programmable timer. A 3-bit register select, a chip select and a read/not-write strobe steer each byte access. Writes either update one of three 8-bit control registers or move 16-bit reload values into a channel. Reads either return the status byte or return a channel's running count. The counters, the mode logic and the interrupt logic sit in a neighbouring block. That block receives the control bytes, the reload strobes and the count-read strobes, and it supplies the live count values and the status byte.

A 16-bit value crosses the 8-bit bus as two bytes, and the block stages one byte of each pair. On a reload, the high byte is written first into a single staging register that all channels share. The low-byte write then moves the full 16 bits in one cycle. On a count read, the high byte is returned directly, and the low byte of the same instant is held in a shared read buffer for the follow-up access. A 16-bit transfer therefore never mixes halves from different moments.

Select 0 reaches two control registers, and bit 0 of control register 2 chooses which one.

Top module: `tmr_regif`

## Requirements
- R1: After a synchronous active-low reset, `ctrl_out` is 24'h000001: control register 1 (bits 7:0) is 8'h01, and control registers 2 (bits 15:8) and 3 (bits 23:16) are zero. `latch_wr` and `cnt_rd` are zero, `latch_val` is zero, and a read of select 3 returns 8'h00.
- R2: A write to select 0 loads control register 1 when bit 0 of control register 2 is 1, and loads control register 3 when that bit is 0. The other control registers keep their values.
- R3: A write to select 1 loads control register 2. A read of select 1 returns `status_in`.
- R4: A write to select 2, 4 or 6 loads one shared high-byte staging register, whichever channel the select names.
- R5: A write to select 3, 5 or 7 raises `latch_wr` bit 0, 1 or 2 for exactly the cycle after the edge. In that cycle `latch_val` is {staged high byte, written byte}, and `latch_val` holds that value until the next such write.
- R6: A read of select 2, 4 or 6 returns bits 15:8 of channel 0, 1 or 2 of `cnt_val`, where channel n occupies bits 16n+15:16n. The edge of that read copies bits 7:0 of the same channel into the shared read buffer, and the matching `cnt_rd` bit is high for the following cycle.
- R7: A read of select 3, 5 or 7 returns the shared read buffer, whichever channel the select names.
- R8: A read of select 0 returns 8'h00. No read changes a control register or the staging register, and only a read of select 2, 4 or 6 changes the read buffer.
- R9: While `cs` is low, no register changes and `latch_wr` and `cnt_rd` stay zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs | input | 1 | Chip select; an access takes effect on an edge where it is high |
| rnw | input | 1 | 1 = read, 0 = write |
| sel | input | 3 | Register select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from `sel` |
| status_in | input | 8 | Status byte from the timer core |
| cnt_val | input | 48 | Live counter values, channel n at bits 16n+15:16n |
| ctrl_out | output | 24 | Control registers 1, 2, 3 at bits 7:0, 15:8, 23:16 |
| latch_wr | output | 3 | One-cycle reload strobe per channel |
| latch_val | output | 16 | Reload value that goes with `latch_wr` |
| cnt_rd | output | 3 | One-cycle count-read strobe per channel |

## Verification
The assertions assume that `sel` only names the eight defined registers and that `cs`, `rnw` and `sel` are stable around the clock edge. They also assume that `cnt_val` is sampled only on the edge of a high-byte read. The stimulus changes every input only at the falling edge, and it draws `sel` from 0 to 7 only. It gives `cnt_val` and `status_in` fresh random values on every access, so a read buffer that captured the wrong moment would show a mismatch. About a fifth of the cycles have `cs` low, which checks that idle cycles leave all state untouched.

// File: rtl/tmr_regif_pkg.sv
// Package: shared decode type and select helpers for the timer register
// interface. Assumes selects 0 and 1 are control/status, and that pairs
// (2,3), (4,5), (6,7) address channels 0, 1, 2.
package tmr_regif_pkg;

    localparam int SEL_W = 3;
    localparam int CH_W  = 2;

    typedef struct packed {
        logic            wr_ctl_a;   // write to shared control slot (sel 0)
        logic            wr_ctl2;    // write to control register 2
        logic            wr_msb;     // write to high-byte staging register
        logic            wr_latch;   // write low byte, commit reload
        logic            rd_cnt;     // read counter high byte, capture low
        logic [CH_W-1:0] ch;         // channel named by the select pair
    } dec_t;

    // Channel index of a paired select (valid for sel >= 2).
    function automatic logic [CH_W-1:0] sel_to_ch(input logic [SEL_W-1:0] s);
        logic [SEL_W-2:0] pair;
        pair = s[SEL_W-1:1];
        return CH_W'(pair - 1'b1);
    endfunction

    // True when the select addresses a channel pair rather than control.
    function automatic logic sel_is_pair(input logic [SEL_W-1:0] s);
        return (s[SEL_W-1:1] != '0);
    endfunction

endpackage

// File: rtl/tmr_regif_dec.sv
// Module: access decoder. Turns chip select, direction and register select
// into one-hot access strobes plus a channel index. Purely combinational;
// assumes inputs are stable around the clock edge.
module tmr_regif_dec
    import tmr_regif_pkg::*;
(
    input  logic             cs,
    input  logic             rnw,
    input  logic [SEL_W-1:0] sel,
    output dec_t             dec
);

    logic wr_en;
    logic rd_en;
    logic pair;

    // Purpose: classify the current access into a single strobe.
    always_comb begin
        wr_en        = cs && !rnw;
        rd_en        = cs && rnw;
        pair         = sel_is_pair(sel);
        dec.wr_ctl_a = wr_en && (sel == SEL_W'(0));
        dec.wr_ctl2  = wr_en && (sel == SEL_W'(1));
        dec.wr_msb   = wr_en && pair && !sel[0];
        dec.wr_latch = wr_en && pair && sel[0];
        dec.rd_cnt   = rd_en && pair && !sel[0];
        dec.ch       = sel_to_ch(sel);
    end

endmodule

// File: rtl/tmr_regif_ctl.sv
// Module: control register bank. Holds three control bytes; the select-0
// slot is steered by bit 0 of control register 2. Reset leaves control
// register 1 bit 0 set so the timers start held in preset.
module tmr_regif_ctl
    import tmr_regif_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  dec_t          dec,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] ctl1,
    output logic [DW-1:0] ctl2,
    output logic [DW-1:0] ctl3
);

    localparam logic [DW-1:0] CTL1_RST = DW'(1);

    // Purpose: update control registers on decoded writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl1 <= CTL1_RST;
            ctl2 <= '0;
            ctl3 <= '0;
        end else begin
            if (dec.wr_ctl2)
                ctl2 <= wdata;
            if (dec.wr_ctl_a && ctl2[0])
                ctl1 <= wdata;
            if (dec.wr_ctl_a && !ctl2[0])
                ctl3 <= wdata;
        end
    end

    // R2: steering keeps the unselected register untouched
    p_steer_keep1_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (dec.wr_ctl_a && !ctl2[0]) |=> $stable(ctl1));
    p_steer_keep3_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (dec.wr_ctl_a && ctl2[0]) |=> $stable(ctl3));
    // R8 / R9: non-control accesses and idle cycles leave the bank alone
    p_ctl_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(dec.wr_ctl_a || dec.wr_ctl2) |=> ($stable(ctl1) && $stable(ctl2) && $stable(ctl3)));

endmodule

// File: rtl/tmr_regif_stage.sv
// Module: 16-bit byte staging. A shared high-byte register collects the
// first half of a reload; the low-byte write commits both halves with a
// one-cycle per-channel strobe. A counter high-byte read captures the low
// byte of the same channel into a shared read buffer.
module tmr_regif_stage
    import tmr_regif_pkg::*;
#(
    parameter int DW  = 8,
    parameter int NCH = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  dec_t              dec,
    input  logic [DW-1:0]     wdata,
    input  logic [NCH*2*DW-1:0] cnt_val,
    output logic [DW-1:0]     lsb_q,
    output logic [NCH-1:0]    latch_wr,
    output logic [2*DW-1:0]   latch_val,
    output logic [NCH-1:0]    cnt_rd
);

    localparam int CW2 = 2 * DW;

    logic [DW-1:0] msb_q;
    logic [DW-1:0] cnt_lo_sel;

    // Purpose: pick the low byte of the addressed channel's count.
    always_comb begin
        cnt_lo_sel = cnt_val[int'(dec.ch)*CW2 +: DW];
    end

    // Purpose: shared staging registers and reload value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msb_q     <= '0;
            lsb_q     <= '0;
            latch_val <= '0;
        end else begin
            if (dec.wr_msb)
                msb_q <= wdata;
            if (dec.wr_latch)
                latch_val <= {msb_q, wdata};
            if (dec.rd_cnt)
                lsb_q <= cnt_lo_sel;
        end
    end

    // Purpose: one strobe flop pair per channel.
    for (genvar g = 0; g < NCH; g++) begin : g_ch
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                latch_wr[g] <= 1'b0;
                cnt_rd[g]   <= 1'b0;
            end else begin
                latch_wr[g] <= dec.wr_latch && (dec.ch == CH_W'(g));
                cnt_rd[g]   <= dec.rd_cnt && (dec.ch == CH_W'(g));
            end
        end
    end

    // R5: at most one reload strobe, and none without a commit write
    p_latch_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(latch_wr));
    p_latch_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !dec.wr_latch |=> (latch_wr == '0) && $stable(latch_val));
    // R6: count-read strobe only after a high-byte read
    p_rd_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !dec.rd_cnt |=> (cnt_rd == '0));
    // R8: read buffer only moves on a high-byte read
    p_lsb_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !dec.rd_cnt |=> $stable(lsb_q));
    // R4: staging register only moves on a high-byte write
    p_msb_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !dec.wr_msb |=> $stable(msb_q));

endmodule

// File: rtl/tmr_regif_rmux.sv
// Module: read data multiplexer. Combinational from the register select;
// select 0 reads as zero, select 1 as status, even pairs as counter high
// byte, odd pairs as the shared read buffer.
module tmr_regif_rmux
    import tmr_regif_pkg::*;
#(
    parameter int DW  = 8,
    parameter int NCH = 3
) (
    input  logic [SEL_W-1:0]    sel,
    input  logic [DW-1:0]       status_in,
    input  logic [NCH*2*DW-1:0] cnt_val,
    input  logic [DW-1:0]       lsb_q,
    output logic [DW-1:0]       rdata
);

    localparam int CW2 = 2 * DW;

    logic [CH_W-1:0] ch;

    // Purpose: route the selected byte to the bus.
    always_comb begin
        ch = sel_to_ch(sel);
        if (!sel_is_pair(sel))
            rdata = sel[0] ? status_in : '0;
        else if (sel[0])
            rdata = lsb_q;
        else
            rdata = cnt_val[int'(ch)*CW2 + DW +: DW];
    end

endmodule

// File: rtl/tmr_regif.sv
// Module: top of the timer register interface. Wires decoder, control
// bank, byte staging and read mux. Assumes one access per chip-select
// cycle and that the timer core samples strobes the cycle they are high.
module tmr_regif
    import tmr_regif_pkg::*;
#(
    parameter int DW  = 8,
    parameter int NCH = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs,
    input  logic               rnw,
    input  logic [SEL_W-1:0]   sel,
    input  logic [DW-1:0]      wdata,
    output logic [DW-1:0]      rdata,
    input  logic [DW-1:0]      status_in,
    input  logic [NCH*2*DW-1:0] cnt_val,
    output logic [3*DW-1:0]    ctrl_out,
    output logic [NCH-1:0]     latch_wr,
    output logic [2*DW-1:0]    latch_val,
    output logic [NCH-1:0]     cnt_rd
);

    dec_t          dec;
    logic [DW-1:0] ctl1, ctl2, ctl3;
    logic [DW-1:0] lsb_q;

    tmr_regif_dec u_dec (
        .cs  (cs),
        .rnw (rnw),
        .sel (sel),
        .dec (dec)
    );

    tmr_regif_ctl #(.DW(DW)) u_ctl (
        .clk   (clk),
        .rst_n (rst_n),
        .dec   (dec),
        .wdata (wdata),
        .ctl1  (ctl1),
        .ctl2  (ctl2),
        .ctl3  (ctl3)
    );

    tmr_regif_stage #(.DW(DW), .NCH(NCH)) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .dec       (dec),
        .wdata     (wdata),
        .cnt_val   (cnt_val),
        .lsb_q     (lsb_q),
        .latch_wr  (latch_wr),
        .latch_val (latch_val),
        .cnt_rd    (cnt_rd)
    );

    tmr_regif_rmux #(.DW(DW), .NCH(NCH)) u_rmux (
        .sel       (sel),
        .status_in (status_in),
        .cnt_val   (cnt_val),
        .lsb_q     (lsb_q),
        .rdata     (rdata)
    );

    // Purpose: pack control bytes for the timer core.
    always_comb begin
        ctrl_out = {ctl3, ctl2, ctl1};
    end

    // R9: idle cycles produce no strobes
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |=> (latch_wr == '0) && (cnt_rd == '0) && $stable(ctrl_out));

endmodule

// File: tb/tmr_regif_tb.sv
`timescale 1ns/1ps
module tmr_regif_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cs, rnw;
    logic [2:0]  sel;
    logic [7:0]  wdata, rdata, status_in;
    logic [47:0] cnt_val;
    logic [23:0] ctrl_out;
    logic [2:0]  latch_wr, cnt_rd;
    logic [15:0] latch_val;

    int n_chk  = 0;
    int n_fail = 0;

    // model state
    logic [7:0]  m_c1, m_c2, m_c3, m_msb, m_lsb;
    logic [15:0] m_lv;

    always #2.5 clk = ~clk;

    tmr_regif u_dut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .rnw(rnw), .sel(sel),
        .wdata(wdata), .rdata(rdata), .status_in(status_in),
        .cnt_val(cnt_val), .ctrl_out(ctrl_out), .latch_wr(latch_wr),
        .latch_val(latch_val), .cnt_rd(cnt_rd)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_rd(input logic [2:0] s);
        int ch;
        ch = int'(s >> 1) - 1;
        if (s == 3'd0) return 8'h00;
        if (s == 3'd1) return status_in;
        if (s[0])      return m_lsb;
        return cnt_val[ch*16 + 8 +: 8];
    endfunction

    // One access: drive at falling edge, check read data, check state after edge.
    task automatic acc(input logic c, input logic r, input logic [2:0] s,
                       input logic [7:0] d);
        logic [2:0] e_lw, e_rd;
        int ch;
        string tg;
        cs = c; rnw = r; sel = s; wdata = d;
        cnt_val = {$urandom, $urandom};
        status_in = 8'($urandom);
        #1;
        tg = (s == 3'd0) ? "R8" : (s == 3'd1) ? "R3" : s[0] ? "R7" : "R6";
        chk(rdata == exp_rd(s), tg, rdata, exp_rd(s));
        ch = int'(s >> 1) - 1;
        e_lw = '0; e_rd = '0;
        if (c && !r) begin
            if (s == 3'd0) begin
                if (m_c2[0]) m_c1 = d; else m_c3 = d;
            end else if (s == 3'd1) m_c2 = d;
            else if (!s[0]) m_msb = d;
            else begin
                e_lw = 3'(1 << ch);
                m_lv = {m_msb, d};
            end
        end else if (c && r && s >= 3'd2 && !s[0]) begin
            e_rd  = 3'(1 << ch);
            m_lsb = cnt_val[ch*16 +: 8];
        end
        @(posedge clk);
        @(negedge clk);
        tg = c ? "R2 R3" : "R9";
        chk(ctrl_out == {m_c3, m_c2, m_c1}, tg, ctrl_out, {m_c3, m_c2, m_c1});
        tg = c ? "R5" : "R9";
        chk(latch_wr == e_lw, tg, latch_wr, e_lw);
        tg = c ? "R4 R5" : "R9";
        chk(latch_val == m_lv, tg, latch_val, m_lv);
        tg = c ? "R6" : "R9";
        chk(cnt_rd == e_rd, tg, cnt_rd, e_rd);
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 1'b0; cs = 1'b0; rnw = 1'b1; sel = 3'd3; wdata = '0;
        status_in = '0; cnt_val = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_c1 = 8'h01; m_c2 = '0; m_c3 = '0; m_msb = '0; m_lsb = '0; m_lv = '0;
        // R1 reset state
        chk(ctrl_out == 24'h000001, "R1", ctrl_out, 24'h000001);
        chk(latch_wr == 3'b0 && cnt_rd == 3'b0, "R1", {latch_wr, cnt_rd}, 0);
        chk(latch_val == 16'h0, "R1", latch_val, 0);
        #1;
        chk(rdata == 8'h00, "R1", rdata, 0);
        // R2 steering: bit0 clear goes to register 3, then set goes to register 1
        acc(1, 0, 3'd0, 8'hA5);
        acc(1, 0, 3'd1, 8'h01);
        acc(1, 0, 3'd0, 8'h5A);
        acc(1, 0, 3'd1, 8'h00);
        acc(1, 0, 3'd0, 8'h3C);
        // R4 shared staging: high byte via select 2, commit on channel 2 (select 7)
        acc(1, 0, 3'd2, 8'hBE);
        acc(1, 0, 3'd7, 8'hEF);
        acc(1, 0, 3'd3, 8'h11);
        // R6/R7 shared read buffer across channels
        acc(1, 1, 3'd2, 8'h00);
        acc(1, 1, 3'd5, 8'h00);
        acc(1, 1, 3'd6, 8'h00);
        acc(1, 1, 3'd3, 8'h00);
        // R8 read of select 0 and 1 has no side effects
        acc(1, 1, 3'd0, 8'h00);
        acc(1, 1, 3'd1, 8'h00);
        // R9 idle with a write pattern on the bus
        acc(0, 0, 3'd7, 8'h77);
        acc(0, 1, 3'd4, 8'h00);
        // random mix
        for (int i = 0; i < 600; i++)
            acc(($urandom % 5) != 0, 1'($urandom), 3'($urandom), 8'($urandom));
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule